// File: doc/BRIEF.md
# CPU Fault Status Register

This block keeps a sticky record of the abort and trap causes that a 16-bit processor's bus and sequencer logic report: an odd-address access, a non-existent-memory access, an I/O page timeout, a HALT outside kernel mode, and yellow-zone or red-zone kernel stack violations. Each cause sets its own bit, and bits accumulate until software clears the register. A write strobe on the register port clears every bit, whatever data was written. A console reset pulse also clears every bit.

The block also judges kernel stack pushes. It compares the push target address with two bounds. An odd target, or a target below the red bound, is a fatal red-stack event. The push is refused, a fatal trap is requested and the stack pointer is forced to a fixed value. A target below the yellow bound completes the write. It then requests a trap, but only while the yellow bit is still clear, so a handler can keep using the stack. Every trap request is a one-cycle pulse toward the sequencer and carries a single vector value.

Top module: `cpu_fault_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register clears to zero and `trap_req`, `trap_fatal` and `sp_load` are low in the next cycle.
- R2: A cycle with `reg_wr` high clears every bit of `reg_rdata` from the next cycle on. The register port has no data input, so the value written has no effect.
- R3: A cycle with `creset` high clears every bit of `reg_rdata` from the next cycle on.
- R4: `ev_odd_addr` sets bit 6 (octal 000100), `ev_nxm` sets bit 5 (octal 000040) and `ev_io_timeout` sets bit 4 (octal 000020). Set bits stay set until a clear, so successive events accumulate.
- R5: `halt_exec` with `mode_user` high sets bit 7 (octal 000200) and requests a trap. With `mode_user` low it has no effect on the register or on the trap outputs.
- R6: A kernel push (`push_valid` and `push_kernel` high) to an even address below YELLOW_BOUND (default octal 0400) and not below RED_BOUND (default octal 0340) sets bit 3 (octal 000010). It keeps `push_ok` high and requests a trap.
- R7: A yellow-zone kernel push made while bit 3 is already set keeps `push_ok` high and requests no trap.
- R8: A kernel push to an odd address, or to an address below RED_BOUND, drives `push_ok` low and sets bit 2 (octal 000004). An odd target also sets bit 6. The next cycle carries `trap_req`, `trap_fatal` and `sp_load` high, with `sp_load_value` equal to octal 4.
- R9: Pushes with `push_kernel` low are not zone-checked: `push_ok` follows `push_valid`, and no bit or trap results.
- R10: `trap_req` is high exactly in the cycle after a trap cause, and low otherwise. `trap_vector` is octal 004.
- R11: When a set cause and a clear (`reg_wr` or `creset`) occur in the same cycle, the set bit is present after the clear.
- R12: Bits 15 to 8 and bits 1 to 0 of `reg_rdata` always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| creset | input | 1 | Console/CPU reset pulse, clears the register |
| reg_wr | input | 1 | Register write strobe, clears the register |
| ev_odd_addr | input | 1 | Odd-address abort this cycle |
| ev_nxm | input | 1 | Non-existent-memory abort this cycle |
| ev_io_timeout | input | 1 | I/O page bus timeout this cycle |
| halt_exec | input | 1 | HALT instruction executed this cycle |
| mode_user | input | 1 | Current processor mode is not kernel |
| push_valid | input | 1 | Stack push requested this cycle |
| push_kernel | input | 1 | The push uses the kernel stack |
| push_addr | input | 16 | Push target address (decremented SP) |
| push_ok | output | 1 | Push write may complete |
| reg_rdata | output | 16 | Register read value |
| trap_req | output | 1 | One-cycle trap request to the sequencer |
| trap_fatal | output | 1 | The trap request is a fatal red-stack trap |
| trap_vector | output | 9 | Trap vector address, octal 004 |
| sp_load | output | 1 | Force the stack pointer this cycle |
| sp_load_value | output | 16 | Forced stack pointer value, octal 4 |

## Verification
A clear (write strobe or console reset) can fall in the same cycle as a new fault cause. The clear must not swallow the new bit. The bench provokes this by pulsing `reg_wr` together with `ev_nxm`, and `creset` together with a yellow push. In the next cycle it expects exactly the new bit. A second overlap pairs a yellow push with an already set yellow bit. There the bench expects the bit to stay set, the write to go ahead and no trap pulse. A behavioural reference model judges both overlaps on every clock.

// File: rtl/cfs_pkg.sv
// Package: bit positions and shared types of the CPU fault status register.
// Assumes a 16-bit register; positions are fixed because software decodes them.
package cfs_pkg;
    localparam int REG_W   = 16;
    localparam int B_HALT  = 7;
    localparam int B_ODD   = 6;
    localparam int B_NXM   = 5;
    localparam int B_IOTO  = 4;
    localparam int B_YEL   = 3;
    localparam int B_RED   = 2;
    localparam int N_TRAP  = 3;   // trap_req, trap_fatal, sp_load

    typedef struct packed {
        logic halt_user;
        logic odd;
        logic nxm;
        logic io_to;
        logic yel;
        logic red;
    } cause_t;
endpackage

// File: rtl/cfs_stack_guard.sv
// Module: cfs_stack_guard
// Classifies a stack push against the red and yellow bounds.
// Only kernel pushes are checked. A red push (odd target or below RED_BOUND)
// is refused. A yellow push completes and traps only while the yellow bit is clear.
module cfs_stack_guard #(
    parameter int          ADDR_W       = 16,
    parameter logic [15:0] YELLOW_BOUND = 16'o400,
    parameter logic [15:0] RED_BOUND    = 16'o340
) (
    input  logic              push_valid,
    input  logic              push_kernel,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              yel_sticky,
    output logic              push_ok,
    output logic              red_hit,
    output logic              red_odd,
    output logic              yel_hit,
    output logic              yel_trap
);
    localparam logic [ADDR_W-1:0] YB = ADDR_W'(YELLOW_BOUND);
    localparam logic [ADDR_W-1:0] RB = ADDR_W'(RED_BOUND);

    logic checked;

    // Purpose: zone comparison and push decision.
    always_comb begin
        checked  = push_valid & push_kernel;
        red_hit  = checked & (push_addr[0] | (push_addr < RB));
        red_odd  = red_hit & push_addr[0];
        yel_hit  = checked & ~red_hit & (push_addr < YB);
        yel_trap = yel_hit & ~yel_sticky;
        push_ok  = push_valid & ~red_hit;
    end
endmodule

// File: rtl/cfs_fault_reg.sv
// Module: cfs_fault_reg
// Sticky error bits. A clear empties the register. Set inputs in the same
// cycle survive the clear. Assumes set_vec only drives the defined positions.
module cfs_fault_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] q
);
    // Purpose: hold, clear and accumulate error bits.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (clr ? '0 : q) | set_vec;
    end

    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> q == '0);
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_vec == '0) |=> q == '0);
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((q & $past(set_vec)) == $past(set_vec)));
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/cfs_trap_gen.sv
// Module: cfs_trap_gen
// Registers the trap request lines into one-cycle pulses toward the sequencer.
// Assumes each request input is valid for the cycle in which it is raised.
module cfs_trap_gen #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    output logic [N-1:0] req_out
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            // Purpose: one flop per request line.
            always_ff @(posedge clk) begin
                if (!rst_n) req_out[g] <= 1'b0;
                else        req_out[g] <= req_in[g];
            end
        end
    endgenerate
endmodule

// File: rtl/cpu_fault_status.sv
// Module: cpu_fault_status (top)
// Sticky CPU fault register with write/console-reset clear, stack zone guard
// and trap pulse generation. Assumes the fault inputs are single-cycle reports.
module cpu_fault_status #(
    parameter logic [15:0] YELLOW_BOUND = 16'o400,
    parameter logic [15:0] RED_BOUND    = 16'o340,
    parameter logic [8:0]  TRAP_VEC     = 9'o004,
    parameter logic [15:0] SP_FORCE     = 16'o4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        creset,
    input  logic        reg_wr,
    input  logic        ev_odd_addr,
    input  logic        ev_nxm,
    input  logic        ev_io_timeout,
    input  logic        halt_exec,
    input  logic        mode_user,
    input  logic        push_valid,
    input  logic        push_kernel,
    input  logic [15:0] push_addr,
    output logic        push_ok,
    output logic [15:0] reg_rdata,
    output logic        trap_req,
    output logic        trap_fatal,
    output logic [8:0]  trap_vector,
    output logic        sp_load,
    output logic [15:0] sp_load_value
);
    import cfs_pkg::*;

    logic              red_hit, red_odd, yel_hit, yel_trap;
    logic [REG_W-1:0]  set_vec, fault_q;
    logic [N_TRAP-1:0] trap_in, trap_out;
    cause_t            cause;

    cfs_stack_guard #(
        .ADDR_W(16), .YELLOW_BOUND(YELLOW_BOUND), .RED_BOUND(RED_BOUND)
    ) u_guard (
        .push_valid (push_valid),
        .push_kernel(push_kernel),
        .push_addr  (push_addr),
        .yel_sticky (fault_q[B_YEL]),
        .push_ok    (push_ok),
        .red_hit    (red_hit),
        .red_odd    (red_odd),
        .yel_hit    (yel_hit),
        .yel_trap   (yel_trap)
    );

    // Purpose: collect causes and map them onto register bit positions.
    always_comb begin
        cause.halt_user = halt_exec & mode_user;
        cause.odd       = ev_odd_addr | red_odd;
        cause.nxm       = ev_nxm;
        cause.io_to     = ev_io_timeout;
        cause.yel       = yel_hit;
        cause.red       = red_hit;
        set_vec         = '0;
        set_vec[B_HALT] = cause.halt_user;
        set_vec[B_ODD]  = cause.odd;
        set_vec[B_NXM]  = cause.nxm;
        set_vec[B_IOTO] = cause.io_to;
        set_vec[B_YEL]  = cause.yel;
        set_vec[B_RED]  = cause.red;
    end

    cfs_fault_reg #(.W(REG_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (reg_wr | creset),
        .set_vec(set_vec),
        .q      (fault_q)
    );

    // Purpose: decide which trap lines fire this cycle.
    always_comb begin
        trap_in[0] = cause.halt_user | ev_odd_addr | ev_nxm | ev_io_timeout
                   | red_hit | yel_trap;
        trap_in[1] = red_hit;
        trap_in[2] = red_hit;
    end

    cfs_trap_gen #(.N(N_TRAP)) u_trap (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (trap_in),
        .req_out(trap_out)
    );

    assign reg_rdata     = fault_q;
    assign trap_req      = trap_out[0];
    assign trap_fatal    = trap_out[1];
    assign sp_load       = trap_out[2];
    assign trap_vector   = TRAP_VEC;
    assign sp_load_value = SP_FORCE;

    a_r7_yellow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (yel_hit && fault_q[B_YEL] && !ev_odd_addr && !ev_nxm && !ev_io_timeout
         && !(halt_exec && mode_user)) |=> !trap_req);
    a_r8_fatal_bundle: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fatal |-> (trap_req && sp_load));
    a_r8_red_refused: assert property (@(posedge clk) disable iff (!rst_n)
        red_hit |-> !push_ok);
    a_r6_yellow_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (yel_hit && !fault_q[B_YEL]) |=> (trap_req && reg_rdata[B_YEL]));
    a_r12_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~16'o374) == 16'h0);
    a_r5_kernel_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_exec && !mode_user && !ev_odd_addr && !ev_nxm && !ev_io_timeout
         && !push_valid) |=> !trap_req);
endmodule

// File: tb/cpu_fault_status_tb_top.sv
module cpu_fault_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        creset = 0, reg_wr = 0, ev_odd_addr = 0, ev_nxm = 0, ev_io_timeout = 0;
    logic        halt_exec = 0, mode_user = 0, push_valid = 0, push_kernel = 0;
    logic [15:0] push_addr = 16'o1000;
    logic        push_ok, trap_req, trap_fatal, sp_load;
    logic [15:0] reg_rdata, sp_load_value;
    logic [8:0]  trap_vector;

    int n_chk = 0;
    int n_fail = 0;
    string phase = "R1";

    // behavioural model state
    int m_reg = 0;
    bit m_trap = 0, m_fatal = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    cpu_fault_status dut_i (
        .clk(clk), .rst_n(rst_n), .creset(creset), .reg_wr(reg_wr),
        .ev_odd_addr(ev_odd_addr), .ev_nxm(ev_nxm), .ev_io_timeout(ev_io_timeout),
        .halt_exec(halt_exec), .mode_user(mode_user), .push_valid(push_valid),
        .push_kernel(push_kernel), .push_addr(push_addr), .push_ok(push_ok),
        .reg_rdata(reg_rdata), .trap_req(trap_req), .trap_fatal(trap_fatal),
        .trap_vector(trap_vector), .sp_load(sp_load), .sp_load_value(sp_load_value)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0o expected %0o", req, act, exp);
        end
    endtask

    // Model update and push_ok check at the rising edge (inputs stable since negedge+1).
    always @(posedge clk) begin
        bit chk, red, yel;
        int sets;
        chk = push_valid && push_kernel;
        red = chk && ((push_addr % 2) == 1 || push_addr < 16'o340);
        yel = chk && !red && push_addr < 16'o400;
        if (rst_n) check({phase, " push_ok"}, int'(push_ok), int'(push_valid && !red));
        if (!rst_n) begin
            m_reg = 0; m_trap = 0; m_fatal = 0;
        end else begin
            sets = 0;
            if (halt_exec && mode_user) sets = sets | 'o200;
            if (ev_odd_addr || (red && push_addr % 2 == 1)) sets = sets | 'o100;
            if (ev_nxm) sets = sets | 'o40;
            if (ev_io_timeout) sets = sets | 'o20;
            if (yel) sets = sets | 'o10;
            if (red) sets = sets | 'o4;
            m_trap = (halt_exec && mode_user) || ev_odd_addr || ev_nxm || ev_io_timeout
                     || red || (yel && (m_reg & 'o10) == 0);
            m_fatal = red;
            m_reg = ((reg_wr || creset) ? 0 : m_reg) | sets;
        end
    end

    // Registered outputs compared on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            check({phase, " model rdata"}, int'(reg_rdata), m_reg);
            check({phase, " model trap_req R10"}, int'(trap_req), int'(m_trap));
            check({phase, " model trap_fatal"}, int'(trap_fatal), int'(m_fatal));
            check({phase, " model sp_load"}, int'(sp_load), int'(m_fatal));
            check("R12 unused bits", int'(reg_rdata & ~16'o374), 0);
        end
    end

    task automatic idle();
        creset = 0; reg_wr = 0; ev_odd_addr = 0; ev_nxm = 0; ev_io_timeout = 0;
        halt_exec = 0; push_valid = 0;
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic pulse();   // hold stimulus one cycle, then outputs show the result
        step(); idle();
    endtask

    initial begin : watchdog
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        repeat (3) step();
        phase = "R1";
        check("R1 reset rdata", int'(reg_rdata), 0);
        check("R1 reset trap", int'(trap_req), 0);
        rst_n = 1; step();

        phase = "R4"; ev_odd_addr = 1; pulse();
        check("R4 odd bit", int'(reg_rdata), 'o100);
        check("R10 trap pulse", int'(trap_req), 1);
        check("R10 vector", int'(trap_vector), 'o4);
        step();
        check("R10 single cycle", int'(trap_req), 0);

        phase = "R2"; reg_wr = 1; pulse();
        check("R2 write clears", int'(reg_rdata), 0);

        phase = "R4"; ev_nxm = 1; pulse(); ev_io_timeout = 1; pulse();
        check("R4 accumulate", int'(reg_rdata), 'o60);

        phase = "R5"; halt_exec = 1; mode_user = 1; pulse(); mode_user = 0;
        check("R5 user halt", int'(reg_rdata), 'o260);
        step();
        halt_exec = 1; pulse();
        check("R5 kernel halt ignored", int'(reg_rdata), 'o260);
        check("R5 kernel halt no trap", int'(trap_req), 0);

        phase = "R3"; creset = 1; pulse();
        check("R3 creset clears", int'(reg_rdata), 0);

        phase = "R6"; push_valid = 1; push_kernel = 1; push_addr = 16'o376; pulse();
        check("R6 yellow bit", int'(reg_rdata), 'o10);
        check("R6 yellow trap", int'(trap_req), 1);
        phase = "R7"; push_valid = 1; push_addr = 16'o374; pulse();
        check("R7 no second trap", int'(trap_req), 0);
        check("R7 bit kept", int'(reg_rdata), 'o10);

        phase = "R11"; creset = 1; push_valid = 1; push_addr = 16'o370; pulse();
        check("R11 yellow survives creset", int'(reg_rdata), 'o10);
        reg_wr = 1; ev_nxm = 1; pulse();
        check("R11 nxm survives write", int'(reg_rdata), 'o40);
        reg_wr = 1; pulse();

        phase = "R8"; push_valid = 1; push_addr = 16'o777; pulse();
        check("R8 odd stack bits", int'(reg_rdata), 'o104);
        check("R8 fatal", int'(trap_fatal), 1);
        check("R8 sp_load", int'(sp_load), 1);
        check("R8 sp value", int'(sp_load_value), 'o4);
        reg_wr = 1; pulse();
        push_valid = 1; push_addr = 16'o300; pulse();
        check("R8 below red bound", int'(reg_rdata), 'o4);
        reg_wr = 1; pulse();

        phase = "R9"; push_valid = 1; push_kernel = 0; push_addr = 16'o376; pulse();
        check("R9 user push ignored", int'(reg_rdata), 0);
        check("R9 no trap", int'(trap_req), 0);

        phase = "mix";
        for (int i = 0; i < 400; i++) begin
            ev_odd_addr   = ($urandom % 11) == 0;
            ev_nxm        = ($urandom % 13) == 0;
            ev_io_timeout = ($urandom % 13) == 0;
            halt_exec     = ($urandom % 9) == 0;
            mode_user     = $urandom % 2;
            push_valid    = $urandom % 3 == 0;
            push_kernel   = $urandom % 4 != 0;
            push_addr     = 16'(16'o200 + ($urandom % 16'o300));
            reg_wr        = ($urandom % 17) == 0;
            creset        = ($urandom % 29) == 0;
            step();
        end
        idle(); step(); step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule